// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a bank of maskable peripheral interrupt lines and a small group of non-maskable trap lines. It presents a single request to the processor, together with the handler-table address that the processor should fetch for the winning source. Each maskable line has an enable, a sticky pending flag and a 3-bit priority. A priority of zero keeps the line silent. When lines share a priority, the one with the lower vector number wins. Traps occupy the lowest vector numbers and rank above every maskable level.

The processor side has four parts: a request output, the vector address output, an acknowledge input and a return input. The block owns the current processor priority level and makes it visible on an output. An acknowledge clears the winner's pending flag and raises the level to the winner's level. The previous level is saved on a small stack, and a return restores it. A control input selects either the primary handler table or the alternate one, which has the same layout and sits directly behind the primary table.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `cpuReq` is low, `cpuLevel` is 0, no flag is pending and the level stack is empty.
- R2: A high `irqIn[i]` or `trapIn[t]` at a clock edge sets that source's pending flag. The flag stays set until the source is acknowledged, so the request is visible from the next cycle and holds while it waits. If a set and a clear of the same flag fall in one edge, the set wins.
- R3: A maskable source whose `irqEnable` bit is 0, or whose priority field is 0, never wins. Its pending flag is still recorded, and the source competes as soon as it is enabled with a nonzero priority.
- R4: Among the eligible maskable sources, the one with the largest priority field `irqPrio[3*i+2:3*i]` wins.
- R5: Among eligible maskable sources with equal priority, the lowest index wins.
- R6: Any pending trap wins over every maskable source, whatever the enables are. Among traps, the lowest index wins. A trap has level 8.
- R7: Trap t has vector number t, and maskable source i has vector number NUM_TRAP+i. `cpuVector` = base + 2·vector. The base is 0x000004 when `altTableEn`=0, and 0x000004 + 2·(NUM_TRAP+NUM_IRQ) when it is 1. With the defaults the alternate base is 0x000030.
- R8: `cpuReq` is high only when a winner exists and its level is strictly greater than `cpuLevel`. This means a trap never preempts a trap.
- R9: `cpuAck` while `cpuReq` is high clears the winner's pending flag, pushes the old `cpuLevel` and loads the winner's level from the next cycle. `cpuAck` while `cpuReq` is low has no effect.
- R10: `cpuRet` pops the stack into `cpuLevel`. It is ignored when the stack is empty, and it is ignored in a cycle where an acknowledge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IRQ | Maskable request lines, sampled each edge |
| trapIn | input | NUM_TRAP | Non-maskable trap lines, sampled each edge |
| irqEnable | input | NUM_IRQ | Per-source enable |
| irqPrio | input | 3·NUM_IRQ | Per-source priority, 3 bits per source |
| altTableEn | input | 1 | Selects the alternate handler table |
| cpuAck | input | 1 | Processor accepts the current request |
| cpuRet | input | 1 | Processor returns from a handler |
| cpuReq | output | 1 | Interrupt request to the processor |
| cpuVector | output | ADDR_W | Handler-table entry address for the winner |
| cpuLevel | output | 4 | Current processor priority level |

## Verification
A corrupted pending flag shows up on `cpuReq` or `cpuVector` in the cycle after the faulty edge. A wrong arbitration choice shows the wrong table address at once. A damaged level stack stays hidden until a return, and then appears as a wrong `cpuLevel` one cycle later. It also appears as a request that is wrongly granted or held back against the restored level. For that reason the directed sequence nests and unwinds several levels and compares both outputs after every return.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam logic [3:0] TRAP_LEVEL = 4'd8;

  typedef struct packed {
    logic take;     // accept winner: clear pending, push level
    logic restore;  // pop saved level
  } irqStrobes_t;
endpackage

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter int NUM_TRAP    = 6,
  parameter int ADDR_W      = 24,
  parameter int STACK_DEPTH = 8,
  parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_IRQ-1:0]    irqIn,
  input  logic [NUM_TRAP-1:0]   trapIn,
  input  logic [NUM_IRQ-1:0]    irqEnable,
  input  logic [3*NUM_IRQ-1:0]  irqPrio,
  input  logic                  altTableEn,
  input  irqStrobes_t           strobes,
  output logic                  cpuReq,
  output logic [ADDR_W-1:0]     cpuVector,
  output logic [3:0]            cpuLevel,
  output logic                  stackEmpty,
  output logic                  stackFull
);
  localparam int NUM_VEC = NUM_TRAP + NUM_IRQ;
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int IRQ_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int TRAP_W  = (NUM_TRAP > 1) ? $clog2(NUM_TRAP) : 1;
  localparam int SP_W    = $clog2(STACK_DEPTH + 1);
  localparam logic [ADDR_W-1:0] ALT_BASE = PRI_BASE + ADDR_W'(2 * NUM_VEC);

  logic [NUM_IRQ-1:0]  pendIrq;
  logic [NUM_TRAP-1:0] pendTrap;
  logic [NUM_IRQ-1:0]  irqClr;
  logic [NUM_TRAP-1:0] trapClr;
  logic [2:0]          prioOf [NUM_IRQ];
  logic [NUM_IRQ-1:0]  eligible;

  // per-source slicing and eligibility
  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_src
      assign prioOf[gi]   = irqPrio[3*gi +: 3];
      assign eligible[gi] = pendIrq[gi] && irqEnable[gi] && (prioOf[gi] != 3'd0);
    end
  endgenerate

  // arbitration: highest level, ties go to the lowest index
  logic [3:0]        bestLvl;
  logic [IRQ_W-1:0]  bestIdx;
  logic              trapHit;
  logic [TRAP_W-1:0] trapIdx;
  logic [3:0]        winLevel;
  logic [VEC_W-1:0]  winVec;
  logic              winValid;

  always_comb begin
    bestLvl = 4'd0;
    bestIdx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i] && ({1'b0, prioOf[i]} > bestLvl)) begin
        bestLvl = {1'b0, prioOf[i]};
        bestIdx = IRQ_W'(i);
      end
    end
    trapHit = 1'b0;
    trapIdx = '0;
    for (int t = NUM_TRAP - 1; t >= 0; t--) begin
      if (pendTrap[t]) begin
        trapHit = 1'b1;
        trapIdx = TRAP_W'(t);
      end
    end
    if (trapHit) begin
      winLevel = TRAP_LEVEL;
      winVec   = VEC_W'(trapIdx);
    end else begin
      winLevel = bestLvl;
      winVec   = VEC_W'(NUM_TRAP) + VEC_W'(bestIdx);
    end
    winValid = trapHit || (bestLvl != 4'd0);
  end

  // pending flags: set wins over clear
  always_comb begin
    irqClr  = '0;
    trapClr = '0;
    if (strobes.take) begin
      if (trapHit) trapClr[trapIdx] = 1'b1;
      else         irqClr[bestIdx]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendIrq  <= '0;
      pendTrap <= '0;
    end else begin
      pendIrq  <= (pendIrq & ~irqClr) | irqIn;
      pendTrap <= (pendTrap & ~trapClr) | trapIn;
    end
  end

  // level register and save stack
  logic [3:0]      levelQ;
  logic [SP_W-1:0] sp;
  logic [3:0]      levelStack [2**SP_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 4'd0;
      sp     <= '0;
    end else if (strobes.take) begin
      levelQ <= winLevel;
      sp     <= sp + 1'b1;
    end else if (strobes.restore) begin
      levelQ <= levelStack[sp - 1'b1];
      sp     <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.take) levelStack[sp] <= levelQ;
  end

  assign cpuReq     = winValid && (winLevel > levelQ);
  assign cpuVector  = (altTableEn ? ALT_BASE : PRI_BASE) + ADDR_W'({winVec, 1'b0});
  assign cpuLevel   = levelQ;
  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
endmodule

// File: rtl/vec_irq_control.sv
module vec_irq_control
  import vec_irq_pkg::*;
(
  input  logic        cpuAck,
  input  logic        cpuRet,
  input  logic        cpuReq,
  input  logic        stackEmpty,
  input  logic        stackFull,
  output irqStrobes_t strobes
);
  always_comb begin
    strobes.take    = cpuAck && cpuReq && !stackFull;
    strobes.restore = cpuRet && !strobes.take && !stackEmpty;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter int NUM_TRAP    = 6,
  parameter int ADDR_W      = 24,
  parameter int STACK_DEPTH = 8,
  parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   irqIn,
  input  logic [NUM_TRAP-1:0]  trapIn,
  input  logic [NUM_IRQ-1:0]   irqEnable,
  input  logic [3*NUM_IRQ-1:0] irqPrio,
  input  logic                 altTableEn,
  input  logic                 cpuAck,
  input  logic                 cpuRet,
  output logic                 cpuReq,
  output logic [ADDR_W-1:0]    cpuVector,
  output logic [3:0]           cpuLevel
);
  irqStrobes_t strobes;
  logic        stackEmpty;
  logic        stackFull;

  vec_irq_control u_ctl (
    .cpuAck(cpuAck), .cpuRet(cpuRet), .cpuReq(cpuReq),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .strobes(strobes)
  );

  vec_irq_datapath #(
    .NUM_IRQ(NUM_IRQ), .NUM_TRAP(NUM_TRAP), .ADDR_W(ADDR_W),
    .STACK_DEPTH(STACK_DEPTH), .PRI_BASE(PRI_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .trapIn(trapIn),
    .irqEnable(irqEnable), .irqPrio(irqPrio), .altTableEn(altTableEn),
    .strobes(strobes), .cpuReq(cpuReq), .cpuVector(cpuVector),
    .cpuLevel(cpuLevel), .stackEmpty(stackEmpty), .stackFull(stackFull)
  );
endmodule

// File: rtl/vec_irq_checker.sv
module vec_irq_checker #(
  parameter int NUM_IRQ     = 16,
  parameter int NUM_TRAP    = 6,
  parameter int ADDR_W      = 24,
  parameter int STACK_DEPTH = 8,
  parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_TRAP-1:0] trapIn,
  input logic                cpuAck,
  input logic                cpuRet,
  input logic                cpuReq,
  input logic [ADDR_W-1:0]   cpuVector,
  input logic [3:0]          cpuLevel
);
  localparam int NUM_VEC = NUM_TRAP + NUM_IRQ;
  localparam int D_W     = $clog2(STACK_DEPTH + 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = PRI_BASE + ADDR_W'(4 * NUM_VEC);

  // shadow nesting depth seen from the ports
  logic [D_W-1:0] depth;
  logic           accepted;
  assign accepted = cpuAck && cpuReq && (depth != D_W'(STACK_DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN)                                depth <= '0;
    else if (accepted)                        depth <= depth + 1'b1;
    else if (cpuRet && depth != '0)           depth <= depth - 1'b1;
  end

  assert_ack_raises_R9: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> cpuLevel > $past(cpuLevel));

  assert_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && !cpuReq && !cpuRet) |=> $stable(cpuLevel));

  assert_ret_lowers_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRet && !accepted && depth != '0) |=> cpuLevel < $past(cpuLevel));

  assert_ret_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRet && !cpuAck && depth == '0) |=> $stable(cpuLevel));

  assert_vector_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuVector[0] == 1'b0 && cpuVector >= PRI_BASE && cpuVector < TOP_ADDR));

  assert_trap_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((|trapIn) && cpuLevel != 4'd8 && !cpuAck) |=> cpuReq);

  assert_no_trap_nesting_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> cpuLevel < 4'd8);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuLevel <= 4'd8);
endmodule

bind vec_irq_ctrl vec_irq_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_TRAP(NUM_TRAP), .ADDR_W(ADDR_W),
  .STACK_DEPTH(STACK_DEPTH), .PRI_BASE(PRI_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .trapIn(trapIn), .cpuAck(cpuAck), .cpuRet(cpuRet),
  .cpuReq(cpuReq), .cpuVector(cpuVector), .cpuLevel(cpuLevel)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/100ps
module sim_vec_irq_ctrl;
  localparam int NI = 16;
  localparam int NT = 6;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NI-1:0]   irqIn;
  logic [NT-1:0]   trapIn;
  logic [NI-1:0]   irqEnable;
  logic [3*NI-1:0] irqPrio;
  logic            altTableEn;
  logic            cpuAck;
  logic            cpuRet;
  logic            cpuReq;
  logic [23:0]     cpuVector;
  logic [3:0]      cpuLevel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .trapIn(trapIn),
    .irqEnable(irqEnable), .irqPrio(irqPrio), .altTableEn(altTableEn),
    .cpuAck(cpuAck), .cpuRet(cpuRet), .cpuReq(cpuReq),
    .cpuVector(cpuVector), .cpuLevel(cpuLevel)
  );

  // two sources (A, B) with priorities, a trap mask, enable, table select
  typedef struct packed {
    logic [3:0] ia; logic [2:0] pa;
    logic [3:0] ib; logic [2:0] pb;
    logic [5:0] trap;
    logic       en;
    logic       alt;
    logic       expReq;
    logic [7:0] expVec;
  } row_t;

  localparam row_t ROWS [10] = '{
    '{4'd3,  3'd5, 4'd3,  3'd5, 6'b000000, 1'b1, 1'b0, 1'b1, 8'h16}, // R2 R7
    '{4'd2,  3'd3, 4'd9,  3'd6, 6'b000000, 1'b1, 1'b0, 1'b1, 8'h22}, // R4
    '{4'd7,  3'd4, 4'd4,  3'd4, 6'b000000, 1'b1, 1'b0, 1'b1, 8'h18}, // R5
    '{4'd1,  3'd0, 4'd1,  3'd0, 6'b000000, 1'b1, 1'b0, 1'b0, 8'h00}, // R3 prio 0
    '{4'd5,  3'd7, 4'd6,  3'd7, 6'b000000, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 disabled
    '{4'd0,  3'd1, 4'd15, 3'd2, 6'b000100, 1'b1, 1'b0, 1'b1, 8'h08}, // R6
    '{4'd0,  3'd1, 4'd0,  3'd1, 6'b101000, 1'b0, 1'b0, 1'b1, 8'h0A}, // R6 maskless
    '{4'd15, 3'd7, 4'd15, 3'd7, 6'b000000, 1'b1, 1'b1, 1'b1, 8'h5A}, // R7 alt
    '{4'd0,  3'd0, 4'd0,  3'd0, 6'b000001, 1'b1, 1'b1, 1'b1, 8'h30}, // R7 alt trap
    '{4'd0,  3'd1, 4'd0,  3'd1, 6'b000000, 1'b1, 1'b0, 1'b1, 8'h10}  // R5 index 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; irqIn = '0; trapIn = '0; cpuAck = 1'b0; cpuRet = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulse(input logic [NI-1:0] im, input logic [NT-1:0] tm);
    irqIn = im; trapIn = tm;
    @(negedge clk);
    irqIn = '0; trapIn = '0;
  endtask

  task automatic ack();
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
  endtask

  task automatic ret();
    cpuRet = 1'b1;
    @(negedge clk);
    cpuRet = 1'b0;
  endtask

  task automatic setPrio(input int idx, input logic [2:0] p);
    irqPrio[3*idx +: 3] = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = '0; trapIn = '0; irqEnable = '0; irqPrio = '0;
    altTableEn = 1'b0; cpuAck = 1'b0; cpuRet = 1'b0;

    // table walk
    foreach (ROWS[k]) begin
      doReset();
      irqPrio = '0;
      setPrio(ROWS[k].ia, ROWS[k].pa);
      setPrio(ROWS[k].ib, ROWS[k].pb);
      irqEnable  = ROWS[k].en ? '1 : '0;
      altTableEn = ROWS[k].alt;
      pulse((NI'(1) << ROWS[k].ia) | (NI'(1) << ROWS[k].ib), ROWS[k].trap);
      chk($sformatf("row%0d R2/R3/R4/R5/R6 req", k), 32'(cpuReq), 32'(ROWS[k].expReq));
      if (ROWS[k].expReq)
        chk($sformatf("row%0d R7 vector", k), 32'(cpuVector), {24'h0, ROWS[k].expVec});
    end

    // R1 reset state
    doReset();
    altTableEn = 1'b0; irqEnable = '1; irqPrio = '0;
    chk("R1 req after reset", 32'(cpuReq), 32'd0);
    chk("R1 level after reset", 32'(cpuLevel), 32'd0);

    // R2, R8, R9, R10 nesting
    setPrio(4, 3'd3); pulse(NI'(1) << 4, '0);
    chk("R2 req src4", 32'(cpuReq), 32'd1);
    chk("R7 vector src4", 32'(cpuVector), 32'h18);
    ack();
    chk("R9 level after ack", 32'(cpuLevel), 32'd3);
    chk("R9 pending cleared", 32'(cpuReq), 32'd0);
    setPrio(8, 3'd2); pulse(NI'(1) << 8, '0);
    chk("R8 lower level held off", 32'(cpuReq), 32'd0);
    setPrio(10, 3'd6); pulse(NI'(1) << 10, '0);
    chk("R4 preempting req", 32'(cpuReq), 32'd1);
    chk("R4 vector src10", 32'(cpuVector), 32'h24);
    ack();
    chk("R9 nested level", 32'(cpuLevel), 32'd6);
    ret();
    chk("R10 pop to 3", 32'(cpuLevel), 32'd3);
    chk("R8 still held at 3", 32'(cpuReq), 32'd0);
    ret();
    chk("R10 pop to 0", 32'(cpuLevel), 32'd0);
    chk("R2 held pending src8 req", 32'(cpuReq), 32'd1);
    chk("R2 held pending src8 vector", 32'(cpuVector), 32'h20);
    ack(); ret();
    chk("R9 all cleared", 32'(cpuReq), 32'd0);
    ret();
    chk("R10 empty ret ignored", 32'(cpuLevel), 32'd0);
    ack();
    chk("R9 ack without req ignored", 32'(cpuLevel), 32'd0);

    // R10 ack and return together
    setPrio(1, 3'd5); pulse(NI'(1) << 1, '0);
    cpuAck = 1'b1; cpuRet = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0; cpuRet = 1'b0;
    chk("R10 ret ignored with ack", 32'(cpuLevel), 32'd5);
    ret();
    chk("R10 back to 0", 32'(cpuLevel), 32'd0);

    // R6 / R8 traps
    pulse('0, 6'b000010);
    chk("R6 trap req", 32'(cpuReq), 32'd1);
    chk("R6 trap1 vector", 32'(cpuVector), 32'h06);
    ack();
    chk("R6 trap level 8", 32'(cpuLevel), 32'd8);
    pulse('0, 6'b000001);
    chk("R8 no trap nesting", 32'(cpuReq), 32'd0);
    ret();
    chk("R6 trap0 after return", 32'(cpuVector), 32'h04);
    ack(); ret();

    // R3 recorded while disabled, R2 set wins over clear
    irqEnable[12] = 1'b0; setPrio(12, 3'd7); pulse(NI'(1) << 12, '0);
    chk("R3 disabled silent", 32'(cpuReq), 32'd0);
    irqEnable[12] = 1'b1; #1;
    chk("R3 enabled later req", 32'(cpuReq), 32'd1);
    chk("R3 enabled later vector", 32'(cpuVector), 32'h28);
    repeat (3) @(negedge clk);
    chk("R2 pending holds", 32'(cpuReq), 32'd1);
    irqIn = NI'(1) << 12; cpuAck = 1'b1;
    @(negedge clk);
    irqIn = '0; cpuAck = 1'b0;
    ret();
    chk("R2 set beats clear", 32'(cpuReq), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule